// File: doc/BRIEF.md
# Gated Prescaled 16-bit Timer

A 16-bit up-counter for timing and event counting. It has three bus registers: control, count and period. The count source is either the internal half-rate clock, a pulse on every second system clock, or rising edges of an external pin. The chosen source passes through a prescaler that divides by 1, 8, 64 or 256. In the normal modes the counter wraps to zero after it reaches the period value and sends a one-cycle interrupt pulse.

In gated mode (internal source only), the counter runs only while the synchronised pin is high. Each falling edge of the pin sends the interrupt pulse and the count is kept, so software can measure how long the pin was high. A stop-in-idle option freezes the timer while the chip's idle input is high.

The controller is a four-state machine:
- **ST_OFF**: disabled.
- **ST_COUNT**: normal counting, from either source.
- **ST_GATED**: gated accumulation.
- **ST_IDLE**: frozen by idle.

Its transitions are:
- **enable**: OFF to COUNT or GATED.
- **disable**: any state to OFF.
- **idle entry**: COUNT or GATED to IDLE.
- **idle exit**: IDLE back to COUNT or GATED.
- **remode**: COUNT to GATED or back, after a control write.

The next state is taken from the control value being written in that cycle, if any, and from the level of the idle input.

Top module: `gtimer_top`

## Requirements
- R1: After reset the control register and the count read 0, the period reads 0xFFFF and irq is low.
- R2: The control register keeps only these bits, all others read 0:
  - bit 15: enable.
  - bit 13: stop-in-idle.
  - bit 6: gate enable.
  - bits 5:4: prescale.
  - bit 1: external source.

  Writing 0xFFFF reads back 0xA072.
- R3: With the internal source at 1:1, the count advances every second clock. The first increment comes on the second rising edge after the edge that wrote the enable.
- R4: The prescale field sets how many source ticks make one increment: 00 = 1, 01 = 8, 10 = 64, 11 = 256. The prescaler restarts on every control write, so after enable the internal source first increments the count after 2·N clocks.
- R5: With enable = 0 the count holds its value.
- R6: In normal mode, a tick that finds the count equal to the period loads 0 into the count instead of incrementing. irq is then high for exactly the one cycle after that edge.
- R7: With stop-in-idle = 1 and idle_in high, the count freezes from the cycle after idle_in is sampled. With stop-in-idle = 0, idle_in has no effect.
- R8: With the external source bit = 1, each rising edge of ext_pin, after a two-flop synchroniser, is one source tick. The gate bit is then ignored.
- R9: In gated mode (gate bit = 1, source bit = 0):
  - The count advances only while the synchronised pin is high.
  - There is no period compare.
  - A falling edge of the pin gives a single irq pulse and leaves the count unchanged.
- R10: A count write loads the value at that edge and wins over a tick in the same cycle.
- R11: Address map: 0 = control, 1 = count, 2 = period. Address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| idle_in | input | 1 | Chip idle indication |
| ext_pin | input | 1 | External clock or gate pin |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions take the following for granted:
- The bus makes at most one access per cycle.
- Inputs are steady at each rising edge.
- ext_pin pulses last at least two clocks, so the no-back-to-back irq property holds in gated mode.

The bench changes every input at falling edges only. It holds each ext_pin level for two clocks or more, and it keeps the period at 0xFFFF except in the wrap test, so that a wrap cannot disturb the prescale measurements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PER = 2'd2;

    localparam int BIT_ON   = 15;
    localparam int BIT_SIDL = 13;
    localparam int BIT_GATE = 6;
    localparam int BIT_PS_L = 4;
    localparam int BIT_EXT  = 1;

    localparam logic [DATA_W-1:0] CTL_MASK = 16'hA072;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_GATED = 2'd2,
        ST_IDLE  = 2'd3
    } tmr_state_e;

    typedef struct packed {
        logic       on;
        logic       sidl;
        logic       gate;
        logic [1:0] ps;
        logic       ext;
    } tmr_ctl_t;

    function automatic tmr_ctl_t ctl_unpack(input logic [DATA_W-1:0] w);
        tmr_ctl_t c;
        c.on   = w[BIT_ON];
        c.sidl = w[BIT_SIDL];
        c.gate = w[BIT_GATE];
        c.ps   = w[BIT_PS_L+1:BIT_PS_L];
        c.ext  = w[BIT_EXT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_pack(input tmr_ctl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_ON]                = c.on;
        w[BIT_SIDL]              = c.sidl;
        w[BIT_GATE]              = c.gate;
        w[BIT_PS_L+1:BIT_PS_L]   = c.ps;
        w[BIT_EXT]               = c.ext;
        return w;
    endfunction
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign lvl  = sh_q[STAGES-1];
    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SEL_W = 2,
    parameter int DIV_W = 8,
    parameter logic [4*(2**SEL_W)-1:0] SHIFTS = {4'd8, 4'd6, 4'd3, 4'd0}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             src,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [DIV_W-1:0] pcnt_q;
    logic [DIV_W-1:0] last;
    logic [3:0]       sh;

    assign sh   = SHIFTS[sel*4 +: 4];
    assign last = DIV_W'((32'd1 << sh) - 32'd1);
    assign tick = src && (pcnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt_q <= '0;
        else if (clr)    pcnt_q <= '0;
        else if (src)    pcnt_q <= (pcnt_q == last) ? '0 : pcnt_q + 1'b1;
    end

    // R4
    pcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= last);
endmodule

// File: rtl/tmr_fsm.sv
module tmr_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tmr_ctl_t   ctl_nxt,
    input  logic       idle_in,
    output tmr_state_e state_q,
    output logic       run,
    output logic       gated
);
    tmr_state_e state_d;
    tmr_state_e mode_st;
    logic       hold;

    always_comb begin
        mode_st = (ctl_nxt.gate && !ctl_nxt.ext) ? ST_GATED : ST_COUNT;
        hold    = ctl_nxt.sidl && idle_in;
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (ctl_nxt.on) state_d = hold ? ST_IDLE : mode_st;
            end
            ST_COUNT, ST_GATED: begin
                if (!ctl_nxt.on) state_d = ST_OFF;
                else if (hold)   state_d = ST_IDLE;
                else             state_d = mode_st;
            end
            ST_IDLE: begin
                if (!ctl_nxt.on) state_d = ST_OFF;
                else if (!hold)  state_d = mode_st;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        run   = 1'b0;
        gated = 1'b0;
        unique case (state_q)
            ST_OFF:   ;
            ST_COUNT: run = 1'b1;
            ST_GATED: begin run = 1'b1; gated = 1'b1; end
            ST_IDLE:  ;
            default:  ;
        endcase
    end

    // R5
    off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_nxt.on |=> state_q == ST_OFF);
endmodule

// File: rtl/gtimer_top.sv
module gtimer_top
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              idle_in,
    input  logic              ext_pin,
    output logic              irq
);
    tmr_ctl_t          ctl_q, ctl_nxt;
    logic [DATA_W-1:0] cnt_q, per_q;
    logic              half_q, irq_q;
    logic              ctl_wr, cnt_wr, per_wr;
    logic              pin_lvl, pin_rise, pin_fall;
    logic              run, gated, clr, src, tick, wrap;
    tmr_state_e        state_q;

    assign ctl_wr  = bus_wr && (bus_addr == ADDR_CTL);
    assign cnt_wr  = bus_wr && (bus_addr == ADDR_CNT);
    assign per_wr  = bus_wr && (bus_addr == ADDR_PER);
    assign ctl_nxt = ctl_wr ? ctl_unpack(bus_wdata) : ctl_q;

    tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_pin),
        .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
    );

    tmr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_nxt(ctl_nxt), .idle_in(idle_in),
        .state_q(state_q), .run(run), .gated(gated)
    );

    assign clr = ctl_wr || (state_q == ST_OFF);
    assign src = run && !ctl_wr && (ctl_q.ext ? pin_rise : half_q);

    tmr_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .src(src),
        .sel(ctl_q.ps), .tick(tick)
    );

    assign wrap = tick && !gated && (cnt_q == per_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            per_q  <= '1;
            cnt_q  <= '0;
            half_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            ctl_q <= ctl_nxt;
            if (per_wr) per_q <= bus_wdata;
            if (clr)      half_q <= 1'b0;
            else if (run) half_q <= ~half_q;
            if (cnt_wr)                   cnt_q <= bus_wdata;
            else if (tick && gated)       cnt_q <= pin_lvl ? cnt_q + 1'b1 : cnt_q;
            else if (wrap)                cnt_q <= '0;
            else if (tick)                cnt_q <= cnt_q + 1'b1;
            irq_q <= (wrap && !cnt_wr) || (gated && pin_fall);
        end
    end

    assign irq = irq_q;

    always_comb begin
        unique case (bus_addr)
            ADDR_CTL: bus_rdata = ctl_pack(ctl_q);
            ADDR_CNT: bus_rdata = cnt_q;
            ADDR_PER: bus_rdata = per_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R10
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(bus_wdata));
    // R5
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !cnt_wr) |=> cnt_q == $past(cnt_q));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cnt_wr) |=> cnt_q == $past(cnt_q));
    // R6
    irq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R2
    ctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTL) |-> ((bus_rdata & ~CTL_MASK) == '0));
endmodule

// File: tb/gtimer_top_bench.sv
module gtimer_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    localparam logic [1:0] V_PS  [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2, 2'd3};
    localparam int         V_WT  [NV] = '{10, 1, 15, 16, 40, 127, 128, 300, 600};
    localparam int         V_EXP [NV] = '{5, 0, 0, 1, 2, 0, 1, 2, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        idle_in = 1'b0;
    logic        ext_pin = 1'b0;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gtimer_top u_gtimer_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_in(idle_in),
        .ext_pin(ext_pin), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1; repeat (2) @(negedge clk);
            ext_pin = 1'b0; repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v, c1, c2;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 ctl", v, 16'h0000);
        rd(2'd1, v); check("R1 cnt", v, 16'h0000);
        rd(2'd2, v); check("R1 per", v, 16'hFFFF);
        check("R1 irq", {15'd0, irq}, 16'h0);

        // R3 R4 table of prescale vectors
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, 16'h0000);
            wr(2'd1, 16'h0000);
            wr(2'd0, 16'h8000 | (16'(V_PS[i]) << 4));
            step(V_WT[i]);
            rd(2'd1, v);
            check($sformatf("R3/R4 vec%0d", i), v, 16'(V_EXP[i]));
        end

        // R2 control readback mask
        wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R2 mask", v, 16'hA072);
        wr(2'd0, 16'h0000); rd(2'd0, v); check("R2 clear", v, 16'h0000);

        // R11 address 3
        wr(2'd3, 16'h5555); rd(2'd3, v); check("R11 addr3", v, 16'h0000);
        rd(2'd2, v); check("R11 per kept", v, 16'hFFFF);

        // R5 disable holds count
        wr(2'd1, 16'h0000); wr(2'd0, 16'h8000); step(10);
        wr(2'd0, 16'h0000); rd(2'd1, c1); step(20); rd(2'd1, v);
        check("R5 hold", v, c1);

        // R6 period wrap and irq
        wr(2'd2, 16'd3); wr(2'd1, 16'h0000); wr(2'd0, 16'h8000);
        step(7); rd(2'd1, v); check("R6 cnt at per", v, 16'd3);
        check("R6 irq before", {15'd0, irq}, 16'h0);
        step(1); rd(2'd1, v); check("R6 wrap", v, 16'd0);
        check("R6 irq pulse", {15'd0, irq}, 16'h1);
        step(1); check("R6 irq one cycle", {15'd0, irq}, 16'h0);
        wr(2'd0, 16'h0000); wr(2'd2, 16'hFFFF);

        // R10 count write wins over tick
        wr(2'd1, 16'h0000); wr(2'd0, 16'h8000); step(1);
        wr(2'd1, 16'h1234); rd(2'd1, v); check("R10 load", v, 16'h1234);
        step(2); rd(2'd1, v); check("R10 next tick", v, 16'h1235);

        // R7 stop in idle
        wr(2'd0, 16'hA000); step(6); idle_in = 1'b1; step(1);
        rd(2'd1, c1); step(20); rd(2'd1, v); check("R7 frozen", v, c1);
        idle_in = 1'b0; step(20); rd(2'd1, v);
        check("R7 resumes", 16'(v > c1), 16'h1);
        wr(2'd0, 16'h8000); idle_in = 1'b1; rd(2'd1, c1); step(20); rd(2'd1, v);
        check("R7 sidl=0 runs", 16'(v >= c1 + 16'd9), 16'h1);
        idle_in = 1'b0;

        // R8 external source, gate bit ignored
        wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd0, 16'h8042);
        pulse(5); step(4); rd(2'd1, v); check("R8 ext 1:1", v, 16'd5);
        wr(2'd1, 16'h0000); wr(2'd0, 16'h8012);
        pulse(7); step(4); rd(2'd1, v); check("R8 ext 1:8 under", v, 16'd0);
        pulse(1); step(4); rd(2'd1, v); check("R8 ext 1:8", v, 16'd1);

        // R9 gated accumulation
        wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd0, 16'h8040);
        step(20); rd(2'd1, v); check("R9 gate low", v, 16'd0);
        ext_pin = 1'b1; step(20); rd(2'd1, c1);
        check("R9 gate high counts", 16'(c1 >= 16'd8 && c1 <= 16'd11), 16'h1);
        ext_pin = 1'b0;
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        check("R9 one irq on fall", 16'(pulses), 16'd1);
        rd(2'd1, c2);
        check("R9 count kept", 16'(c2 >= c1 && c2 != 16'd0), 16'h1);
        step(10); rd(2'd1, v); check("R9 stopped", v, c2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule